// File: doc/BRIEF.md
# Single-Channel Bus-Master Block Mover

This block copies a block of words between one peripheral and memory so the CPU does not have to. Software programs a start address, a word count and a control word through a small register port. Once enabled and the peripheral asks for service, the block requests the system bus. After the CPU grants it, the block drives the memory address and strobes and moves one word per accepted handshake. At the end it hands the bus back and flags completion, with an optional interrupt.

There are three pacing modes. Burst keeps the bus for the whole block. Single gives the bus back after every word and asks again. Transparent keeps the bus but moves a word only in cycles where the CPU marks the bus idle. A circular option reloads the programmed address and count at the end of each block, so a stream can run without stopping.

The peripheral side is a valid/ready pair. `per_req` is the peripheral's valid (toward memory) or ready (from memory). `per_ack` is the block's acceptance and is high only in the cycle a word moves. While `per_req` is high the peripheral must hold `per_wdata` stable. A low `per_req` is back-pressure: the block waits, keeping the bus in burst and transparent modes. Memory is assumed to answer a read in the same cycle as `mem_rd`.

Top module: `blk_dma`

## Requirements
- R1: After reset, `bus_req`, `per_ack`, `mem_rd`, `mem_wr` and `irq` are 0, and all four registers read 0.
- R2: A register access happens only when `reg_cs`, `reg_rsel` and not `bus_grant` all hold. The offsets are: 0 for the current address (a write also sets the reload address), 1 for the current count (a write also sets the reload count), 2 for control, and 3 for status. Control holds bit0 enable, bit1 direction (0 peripheral to memory, 1 memory to peripheral), bits3:2 mode (00 burst, 01 single, 10 transparent), bit4 circular and bit5 interrupt enable. Status bit0 is done, and writing 1 clears it. While the bus is granted, writes are ignored and reads return 0.
- R3: When enable is set, the count is nonzero and `per_req` is high, `bus_req` rises on the next clock edge. No word moves unless `bus_grant` is 1.
- R4: One word moves in each cycle where the block owns the bus, `bus_grant` and `per_req` are high and the mode's pacing allows it. In that cycle `per_ack` is 1 and `mem_addr` is the current address. Toward memory, `mem_wr` is 1 and `mem_wdata` equals `per_wdata`. From memory, `mem_rd` is 1 and `per_rdata` equals `mem_rdata`. After the word the address rises by 1 and the count falls by 1.
- R5: In burst mode `bus_req` stays high from grant until the last word, even while `per_req` is low.
- R6: In single mode `bus_req` is 0 in the cycle after each word. It is raised again only after `bus_grant` has gone low.
- R7: In transparent mode a word moves only in cycles where `cpu_bus_idle` is 1.
- R8: After the last word of a non-circular block, `bus_req` is 0 on the next cycle, done is set and enable clears. `irq` equals done AND interrupt enable.
- R9: In circular mode the last word reloads the address and count from their programmed values and sets done, and the channel keeps running.
- R10: Writing control with enable set while the count is 0 sets done and leaves enable clear. The bus is never requested.
- R11: Clearing enable while the bus is not granted stops the channel before the next word. The remaining count stays readable and no further request is made.
- R12: `mem_rd` and `mem_wr` are never high together, and neither is high without `bus_grant`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_cs | input | 1 | Register port chip select |
| reg_rsel | input | 1 | Register select strobe |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_off | input | 2 | Register offset |
| reg_wdata | input | RW | Register write data |
| reg_rdata | output | RW | Register read data, 0 when not selected |
| bus_req | output | 1 | Bus request to the CPU |
| bus_grant | input | 1 | Bus grant from the CPU |
| cpu_bus_idle | input | 1 | CPU is not using the bus this cycle |
| mem_addr | output | AW | Memory word address, 0 when the bus is not owned |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data (same cycle) |
| per_req | input | 1 | Peripheral valid/ready |
| per_ack | output | 1 | Word accepted this cycle |
| per_wdata | input | DW | Peripheral data toward memory |
| per_rdata | output | DW | Memory data toward peripheral |
| irq | output | 1 | Completion interrupt |

## Verification
The assertions watch, every cycle, the local rules of a word move. These are: strobes only under grant and never both, acknowledge only with a request, acknowledge only on idle cycles in transparent mode, and the address and count stepping by one. They also cover the bus release after a single-mode word or a final burst word, the done flag after a wrap, and that no request begins with a zero count. Whether whole blocks land at the right memory words, that register writes under grant are ignored, that a disabled channel keeps its remaining count, and that reads return the programmed values can only be shown by the bench's scenarios.

// File: rtl/blk_dma_pkg.sv
package blk_dma_pkg;
  typedef enum logic [1:0] {
    MD_BURST  = 2'b00,
    MD_SINGLE = 2'b01,
    MD_TRANS  = 2'b10,
    MD_RSVD   = 2'b11
  } mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ASK  = 2'd1,
    ST_OWN  = 2'd2,
    ST_BACK = 2'd3
  } st_e;

  // packed: the last member sits at bit 0
  typedef struct packed {
    logic  ie;
    logic  circ;
    mode_e mode;
    logic  dir;
    logic  en;
  } ctl_t;

  localparam int CTLW = $bits(ctl_t);

  localparam logic [1:0] OFF_ADDR = 2'd0;
  localparam logic [1:0] OFF_CNT  = 2'd1;
  localparam logic [1:0] OFF_CTL  = 2'd2;
  localparam logic [1:0] OFF_STAT = 2'd3;
endpackage

// File: rtl/blk_dma_regs.sv
module blk_dma_regs
  import blk_dma_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16,
  parameter int RW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    off,
  input  logic [RW-1:0] wr_data,
  input  logic          beat,
  output logic          last,
  output logic [AW-1:0] cur_addr,
  output logic [CW-1:0] cur_cnt,
  output ctl_t          ctl_q,
  output logic          done_q,
  output logic [RW-1:0] rd_data
);
  logic [AW-1:0] start_addr;
  logic [CW-1:0] start_cnt;
  logic          unused_wd;

  assign unused_wd = ^wr_data;
  assign last      = beat && (cur_cnt == CW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_addr <= '0;
      start_cnt  <= '0;
      cur_addr   <= '0;
      cur_cnt    <= '0;
      ctl_q      <= '0;
      done_q     <= 1'b0;
    end else begin
      if (beat) begin
        if (last && ctl_q.circ) begin
          cur_addr <= start_addr;
          cur_cnt  <= start_cnt;
        end else begin
          cur_addr <= cur_addr + AW'(1);
          cur_cnt  <= cur_cnt - CW'(1);
        end
        if (last) begin
          done_q <= 1'b1;
          if (!ctl_q.circ) ctl_q.en <= 1'b0;
        end
      end
      if (wr_en) begin
        case (off)
          OFF_ADDR: begin
            start_addr <= wr_data[AW-1:0];
            cur_addr   <= wr_data[AW-1:0];
          end
          OFF_CNT: begin
            start_cnt <= wr_data[CW-1:0];
            cur_cnt   <= wr_data[CW-1:0];
          end
          OFF_CTL: begin
            ctl_q <= ctl_t'(wr_data[CTLW-1:0]);
            if (wr_data[0] && (cur_cnt == '0)) begin
              ctl_q.en <= 1'b0;
              done_q   <= 1'b1;
            end
          end
          default: begin
            if (wr_data[0]) done_q <= 1'b0;
          end
        endcase
      end
    end
  end

  always_comb begin
    case (off)
      OFF_ADDR: rd_data = RW'(cur_addr);
      OFF_CNT:  rd_data = RW'(cur_cnt);
      OFF_CTL:  rd_data = RW'(ctl_q);
      default:  rd_data = RW'(done_q);
    endcase
  end
endmodule

// File: rtl/blk_dma_seq.sv
module blk_dma_seq
  import blk_dma_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  en,
  input  logic  cnt_nz,
  input  logic  circ,
  input  mode_e mode,
  input  logic  per_req,
  input  logic  grant,
  input  logic  cpu_idle,
  input  logic  last,
  output logic  beat,
  output logic  owned,
  output logic  bus_req
);
  st_e st_q, st_d;
  logic pace_ok;

  assign pace_ok = (mode != MD_TRANS) || cpu_idle;
  assign owned   = (st_q == ST_OWN) && grant;
  assign beat    = owned && per_req && pace_ok;
  assign bus_req = (st_q == ST_ASK) || (st_q == ST_OWN);

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE: if (en && cnt_nz && per_req) st_d = ST_ASK;
      ST_ASK: begin
        if (!en || !cnt_nz) st_d = ST_IDLE;
        else if (grant)     st_d = ST_OWN;
      end
      ST_OWN: begin
        if (beat && ((last && !circ) || (mode == MD_SINGLE))) st_d = ST_BACK;
      end
      default: if (!grant) st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end
endmodule

// File: rtl/blk_dma.sv
module blk_dma
  import blk_dma_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16,
  parameter int DW = 16,
  parameter int RW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_cs,
  input  logic          reg_rsel,
  input  logic          reg_we,
  input  logic [1:0]    reg_off,
  input  logic [RW-1:0] reg_wdata,
  output logic [RW-1:0] reg_rdata,
  output logic          bus_req,
  input  logic          bus_grant,
  input  logic          cpu_bus_idle,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          per_req,
  output logic          per_ack,
  input  logic [DW-1:0] per_wdata,
  output logic [DW-1:0] per_rdata,
  output logic          irq
);
  logic          access;
  logic          beat;
  logic          last;
  logic          owned;
  logic [AW-1:0] cur_addr;
  logic [CW-1:0] cur_cnt;
  ctl_t          ctl_q;
  logic          done_q;
  logic [RW-1:0] rd_data;

  assign access = reg_cs && reg_rsel && !bus_grant;

  blk_dma_regs #(.AW(AW), .CW(CW), .RW(RW)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (access && reg_we),
    .off      (reg_off),
    .wr_data  (reg_wdata),
    .beat     (beat),
    .last     (last),
    .cur_addr (cur_addr),
    .cur_cnt  (cur_cnt),
    .ctl_q    (ctl_q),
    .done_q   (done_q),
    .rd_data  (rd_data)
  );

  blk_dma_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (ctl_q.en),
    .cnt_nz   (cur_cnt != '0),
    .circ     (ctl_q.circ),
    .mode     (ctl_q.mode),
    .per_req  (per_req),
    .grant    (bus_grant),
    .cpu_idle (cpu_bus_idle),
    .last     (last),
    .beat     (beat),
    .owned    (owned),
    .bus_req  (bus_req)
  );

  assign reg_rdata = access ? rd_data : '0;
  assign mem_addr  = owned ? cur_addr : '0;
  assign mem_rd    = beat && ctl_q.dir;
  assign mem_wr    = beat && !ctl_q.dir;
  assign mem_wdata = per_wdata;
  assign per_rdata = mem_rdata;
  assign per_ack   = beat;
  assign irq       = done_q && ctl_q.ie;
endmodule

// File: rtl/blk_dma_chk.sv
module blk_dma_chk #(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_req,
  input logic          bus_grant,
  input logic          cpu_bus_idle,
  input logic          mem_rd,
  input logic          mem_wr,
  input logic          per_req,
  input logic          per_ack,
  input logic [1:0]    mode,
  input logic          circ,
  input logic          done,
  input logic [AW-1:0] cur_addr,
  input logic [CW-1:0] cur_cnt
);
  AST_STROBE_NEEDS_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || mem_wr) |-> bus_grant); // R12
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr)); // R12
  AST_ACK_UNDER_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    per_ack |-> (bus_grant && per_req)); // R3
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (per_ack && cur_cnt != CW'(1)) |=> cur_addr == AW'($past(cur_addr) + AW'(1))); // R4
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (per_ack && cur_cnt != CW'(1)) |=> cur_cnt == CW'($past(cur_cnt) - CW'(1))); // R4
  AST_BURST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(bus_req) && mode == 2'b00 && $past(bus_grant)) |-> $past(per_ack && cur_cnt == CW'(1))); // R5
  AST_SINGLE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (per_ack && mode == 2'b01) |=> !bus_req); // R6
  AST_TRANS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (per_ack && mode == 2'b10) |-> cpu_bus_idle); // R7
  AST_FINISH_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (per_ack && cur_cnt == CW'(1) && !circ) |=> (!bus_req && done)); // R8
  AST_WRAP_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (per_ack && cur_cnt == CW'(1) && circ) |=> done); // R9
  AST_REQ_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_req) |-> cur_cnt != '0); // R10
endmodule

bind blk_dma blk_dma_chk #(.AW(AW), .CW(CW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_req      (bus_req),
  .bus_grant    (bus_grant),
  .cpu_bus_idle (cpu_bus_idle),
  .mem_rd       (mem_rd),
  .mem_wr       (mem_wr),
  .per_req      (per_req),
  .per_ack      (per_ack),
  .mode         (ctl_q.mode),
  .circ         (ctl_q.circ),
  .done         (done_q),
  .cur_addr     (cur_addr),
  .cur_cnt      (cur_cnt)
);

// File: tb/sim_blk_dma.sv
module sim_blk_dma;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        reg_cs = 0, reg_rsel = 0, reg_we = 0;
  logic [1:0]  reg_off = 0;
  logic [15:0] reg_wdata = 0, reg_rdata;
  logic        bus_req, bus_grant = 0, cpu_bus_idle = 1;
  logic [15:0] mem_addr, mem_wdata, mem_rdata, per_wdata, per_rdata;
  logic        mem_rd, mem_wr, per_req = 0, per_ack, irq;

  blk_dma u0 (
    .clk(clk), .rst_n(rst_n), .reg_cs(reg_cs), .reg_rsel(reg_rsel), .reg_we(reg_we),
    .reg_off(reg_off), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_req(bus_req),
    .bus_grant(bus_grant), .cpu_bus_idle(cpu_bus_idle), .mem_addr(mem_addr), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .per_req(per_req),
    .per_ack(per_ack), .per_wdata(per_wdata), .per_rdata(per_rdata), .irq(irq)
  );

  int checks = 0, errors = 0, cyc = 0;
  int ack_cnt = 0, bad_idle = 0, req_cycles = 0;
  bit idle_toggle = 0;
  logic [15:0] mem [0:255];

  assign mem_rdata = mem[mem_addr[7:0]];
  assign per_wdata = 16'hA000 + ack_cnt[15:0];

  task automatic chk(input string tag, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h", tag, what, got, exp);
    end
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // CPU side of the bus handshake: grant follows request one half cycle later
  always @(negedge clk) bus_grant <= bus_req;
  always @(negedge clk) cpu_bus_idle <= idle_toggle ? (cyc % 3 == 0) : 1'b1;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;
    if (per_ack) ack_cnt <= ack_cnt + 1;
    if (per_ack && !cpu_bus_idle) bad_idle <= bad_idle + 1;
    if (bus_req) req_cycles <= req_cycles + 1;
    if (cyc > 20000) begin
      errors++;
      $display("FAIL R3 watchdog actual %0d expected %0d", cyc, 20000);
      finish_run();
    end
  end

  // behavioural reference model
  logic [15:0] m_addr, m_cnt, m_sa, m_sc;
  bit m_en, m_dir, m_circ, m_ie, m_done;
  int m_mode, m_ph;

  always @(posedge clk) begin
    bit bt, acc;
    int nph;
    if (!rst_n) begin
      m_addr = 0; m_cnt = 0; m_sa = 0; m_sc = 0;
      m_en = 0; m_dir = 0; m_circ = 0; m_ie = 0; m_done = 0; m_mode = 0; m_ph = 0;
    end else begin
      bt  = (m_ph == 2) && bus_grant && per_req && (m_mode != 2 || cpu_bus_idle);
      acc = reg_cs && reg_rsel && reg_we && !bus_grant;
      nph = m_ph;
      case (m_ph)
        0: if (m_en && m_cnt != 0 && per_req) nph = 1;
        1: if (!m_en || m_cnt == 0) nph = 0; else if (bus_grant) nph = 2;
        2: if (bt && ((m_cnt == 1 && !m_circ) || m_mode == 1)) nph = 3;
        default: if (!bus_grant) nph = 0;
      endcase
      if (bt) begin
        if (m_cnt == 1) begin
          m_done = 1;
          if (m_circ) begin m_addr = m_sa; m_cnt = m_sc; end
          else begin m_en = 0; m_addr = m_addr + 1; m_cnt = 0; end
        end else begin
          m_addr = m_addr + 1; m_cnt = m_cnt - 1;
        end
      end
      if (acc) begin
        case (reg_off)
          2'd0: begin m_addr = reg_wdata; m_sa = reg_wdata; end
          2'd1: begin m_cnt = reg_wdata; m_sc = reg_wdata; end
          2'd2: begin
            m_en = reg_wdata[0]; m_dir = reg_wdata[1]; m_mode = reg_wdata[3:2];
            m_circ = reg_wdata[4]; m_ie = reg_wdata[5];
            if (reg_wdata[0] && m_cnt == 0) begin m_en = 0; m_done = 1; end
          end
          default: if (reg_wdata[0]) m_done = 0;
        endcase
      end
      m_ph = nph;
    end
  end

  // cycle-by-cycle comparison, away from the edges
  always @(negedge clk) begin
    bit eb;
    #3;
    if (rst_n) begin
      eb = (m_ph == 2) && bus_grant && per_req && (m_mode != 2 || cpu_bus_idle);
      chk(m_mode == 1 ? "R6" : "R5", "bus_req", bus_req, (m_ph == 1 || m_ph == 2));
      chk(m_mode == 2 ? "R7" : "R4", "per_ack", per_ack, eb);
      chk("R12", "mem_rd&mem_wr", mem_rd && mem_wr, 0);
      chk("R8", "irq", irq, m_done && m_ie);
      if (eb) begin
        chk("R4", "mem_addr", mem_addr, m_addr);
        chk("R4", "mem_rd", mem_rd, m_dir);
        chk("R4", "mem_wr", mem_wr, !m_dir);
        if (m_dir) chk("R4", "per_rdata", per_rdata, mem[m_addr[7:0]]);
        else       chk("R4", "mem_wdata", mem_wdata, per_wdata);
      end
    end
  end

  task automatic tick();
    @(negedge clk); #1;
  endtask

  task automatic wr(input logic [1:0] off, input logic [15:0] d);
    reg_cs = 1; reg_rsel = 1; reg_we = 1; reg_off = off; reg_wdata = d;
    tick();
    reg_cs = 0; reg_rsel = 0; reg_we = 0;
  endtask

  task automatic rd(input logic [1:0] off, input int exp, input string tag);
    reg_cs = 1; reg_rsel = 1; reg_we = 0; reg_off = off;
    #1 chk(tag, $sformatf("reg[%0d]", off), reg_rdata, exp);
    tick();
    reg_cs = 0; reg_rsel = 0;
  endtask

  task automatic wait_quiet();
    int q = 0;
    while (q < 3) begin
      tick();
      if (!bus_req && !bus_grant) q++; else q = 0;
    end
  endtask

  initial begin
    int base, rq;
    for (int i = 0; i < 256; i++) mem[i] = 16'h5000 + 16'(i);
    repeat (3) tick();
    rst_n = 1;
    tick();
    // R1 reset state
    chk("R1", "bus_req", bus_req, 0);
    chk("R1", "irq", irq, 0);
    chk("R1", "strobes", mem_rd | mem_wr | per_ack, 0);
    for (int k = 0; k < 4; k++) rd(2'(k), 0, "R1");

    // burst, peripheral to memory
    wr(0, 16'h0010); wr(1, 4); wr(2, 16'h0021);
    per_req = 1;
    wait_quiet();
    for (int k = 0; k < 4; k++) chk("R4", "mem word", mem[16 + k], 16'hA000 + k);
    chk("R8", "irq", irq, 1);
    rd(3, 1, "R8"); rd(2, 16'h0020, "R8"); rd(1, 0, "R8"); rd(0, 16'h0014, "R4");
    wr(3, 1); rd(3, 0, "R2");
    chk("R2", "irq after clear", irq, 0);

    // single, memory to peripheral, with a write attempted under grant
    wr(0, 16'h0010); wr(1, 4); wr(2, 16'h0007);
    while (!bus_grant) tick();
    rd(0, 0, "R2");
    while (!bus_grant) tick();
    wr(0, 16'h0055);
    wait_quiet();
    rd(0, 16'h0014, "R2"); rd(1, 0, "R6");

    // transparent, peripheral to memory, CPU busy two cycles in three
    idle_toggle = 1;
    base = ack_cnt;
    wr(0, 16'h0040); wr(1, 5); wr(2, 16'h0009);
    wait_quiet();
    idle_toggle = 0;
    chk("R7", "acks on busy cycles", bad_idle, 0);
    chk("R7", "words moved", ack_cnt - base, 5);
    chk("R7", "last word", mem[16'h44], 16'hA000 + base + 4);

    // zero count start
    per_req = 0;
    wr(1, 0); wr(3, 1); wr(2, 16'h0021);
    per_req = 1;
    rq = req_cycles;
    repeat (10) tick();
    rd(3, 1, "R10"); rd(2, 16'h0020, "R10");
    chk("R10", "request cycles", req_cycles - rq, 0);
    wr(3, 1);

    // circular single mode, seven words over a three-word block
    wr(0, 16'h0080); wr(1, 3);
    base = ack_cnt;
    wr(2, 16'h0015);
    while (ack_cnt != base + 7) tick();
    per_req = 0;
    wait_quiet();
    rd(0, 16'h0081, "R9"); rd(1, 2, "R9"); rd(3, 1, "R9"); rd(2, 16'h0015, "R9");

    // disable mid-block: remaining count kept, no further request
    wr(2, 16'h0014);
    per_req = 1;
    rq = req_cycles;
    repeat (10) tick();
    chk("R11", "request cycles", req_cycles - rq, 0);
    rd(1, 2, "R11"); rd(0, 16'h0081, "R11");
    per_req = 0;
    repeat (3) tick();
    finish_run();
  end
endmodule